// File: doc/BRIEF.md
# EDO DRAM access cycle generator

This block sits between a simple valid/ready host port and a 16-bit page-mode DRAM. It has separate strobes for the low byte and the high byte. Each accepted request becomes one complete, single-word memory cycle. The row half of the address goes onto the shared address pins and the row strobe falls. After a programmable delay the column half replaces it and the column strobes fall. After the access time all strobes rise and a precharge interval follows. Only then does the block take the next request.

Writes are always issued in early-write order: the write strobe is low before either column strobe falls. The output enable stays high, so the memory never drives the data pins while the controller does. The byte enables pick which column strobe pulses on a write. Reads pulse both strobes. Read data is sampled while the output enable is still low and is returned with a one-cycle valid pulse. A refresh grant input keeps new requests from being accepted, so an external refresh engine can own the pins. Every delay is a parameter counted in clock cycles.

Top module: `edo_access_ctrl`

## Requirements
- R1: After reset, with no refresh grant, `req_ready_o` is 1, `rsp_valid_o` is 0, all five strobes are high and `dram_dq_oe_o` is 0.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` then stays 0 for T_RCD+T_CAS+T_RP cycles.
- R3: For the T_RCD cycles after acceptance, `dram_ras_no` is 0 and both column strobes are high. `dram_a_o` carries the row, which is `req_addr_i[ROW_W+COL_W-1:COL_W]`.
- R4: For the next T_CAS cycles, `dram_ras_no` stays 0. `dram_a_o` carries the column, which is `req_addr_i[COL_W-1:0]`, and the column strobes are active. A column strobe is never low while `dram_ras_no` is high.
- R5: On a write, `dram_lcas_no` is low in the column phase only if `req_be_i[0]` is 1 (data bits 7:0), and `dram_ucas_no` is low only if `req_be_i[1]` is 1 (bits 15:8). A write with both enables 0 pulses neither strobe. A read pulses both strobes whatever the enables are.
- R6: On a write, `dram_we_no` is 0 from the first row-phase cycle through the last column-phase cycle, so it falls before any column strobe. On a read, and outside accesses, it is 1.
- R7: `dram_oe_no` is 0 only during the column phase of a read. It is 1 during every cycle of a write.
- R8: `dram_dq_oe_o` is 1, and `dram_dq_o` equals the write data, only during the row and column phases of a write. At all other times `dram_dq_oe_o` is 0.
- R9: A read samples `dram_dq_i` on the clock edge that ends the last column-phase cycle. In the next cycle `rsp_valid_o` is 1 for exactly one cycle and `rsp_rdata_o` holds the sampled value. A write produces no `rsp_valid_o` pulse.
- R10: After the column phase, all strobes are high and `dram_dq_oe_o` is 0 for T_RP cycles. `req_ready_o` returns to 1 in the cycle after that.
- R11: While `refresh_grant_i` is 1, `req_ready_o` is 0, no request is accepted and `dram_ras_no` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte enables; bit 0 low byte, bit 1 high byte |
| req_addr_i | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | 16 | Read data |
| refresh_grant_i | input | 1 | Refresh owns the memory; blocks acceptance |
| dram_a_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_lcas_no | output | 1 | Low-byte column strobe, active low |
| dram_ucas_no | output | 1 | High-byte column strobe, active low |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Data toward memory |
| dram_dq_oe_o | output | 1 | Enable for the controller's data pin drivers |
| dram_dq_i | input | 16 | Data from memory |

## Verification
The row phase shows on the pins in the cycle right after the accepting edge. The column phase starts T_RCD cycles later, and the precharge phase starts T_RCD+T_CAS cycles after acceptance. The read response appears in the first precharge cycle, and ready returns T_RCD+T_CAS+T_RP cycles after acceptance. The bench drives inputs on falling edges and counts every phase cycle by cycle. It checks each pin on the falling edge of every cycle, so each result is compared in exactly the cycle it is due. The memory model returns the read value only while the output enable is low, which shows whether the capture edge is right.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2,
    PH_PRE  = 2'd3
  } phase_e;
endpackage

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 3,
  parameter int unsigned T_RP  = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   col_last_o
);
  localparam int unsigned MAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int unsigned MAX_D = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int unsigned CNT_W = (MAX_D > 1) ? $clog2(MAX_D) : 1;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_ROW;
          cnt_q   <= CNT_W'(T_RCD - 1);
        end
        PH_ROW: if (cnt_q == '0) begin
          phase_q <= PH_COL;
          cnt_q   <= CNT_W'(T_CAS - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_COL: if (cnt_q == '0) begin
          phase_q <= PH_PRE;
          cnt_q   <= CNT_W'(T_RP - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PRE: if (cnt_q == '0) phase_q <= PH_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign col_last_o = (phase_q == PH_COL) && (cnt_q == '0);
endmodule

// File: rtl/edo_req_latch.sv
module edo_req_latch #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              we_o,
  output logic [BE_W-1:0]   be_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      be_o    <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      we_o    <= we_i;
      be_o    <= be_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/edo_pin_drv.sv
module edo_pin_drv
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  phase_e            phase_i,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [MA_W-1:0]   a_o,
  output logic              ras_no,
  output logic              lcas_no,
  output logic              ucas_no,
  output logic              we_no,
  output logic              oe_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic in_row, in_col, active;
  logic [1:0] lane_sel;

  assign in_row = (phase_i == PH_ROW);
  assign in_col = (phase_i == PH_COL);
  assign active = in_row | in_col;
  // reads open both lanes; writes follow the byte enables
  assign lane_sel = we_i ? be_i : 2'b11;

  always_comb begin
    a_o = '0;
    if (in_row)      a_o[ROW_W-1:0] = addr_i[ADDR_W-1:COL_W];
    else if (in_col) a_o[COL_W-1:0] = addr_i[COL_W-1:0];
  end

  assign ras_no  = ~active;
  assign lcas_no = ~(in_col & lane_sel[0]);
  assign ucas_no = ~(in_col & lane_sel[1]);
  // early write: WE already low through the row phase
  assign we_no   = ~(active & we_i);
  assign oe_no   = ~(in_col & ~we_i);
  assign dq_oe_o = active & we_i;
  assign dq_o    = wdata_i;
endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) data_o <= dq_i;
    end
  end
endmodule

// File: rtl/edo_access_ctrl.sv
module edo_access_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned COL_W = 10,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 3,
  parameter int unsigned T_RP  = 2,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [1:0]        req_be_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_rdata_o,
  input  logic              refresh_grant_i,
  output logic [MA_W-1:0]   dram_a_o,
  output logic              dram_ras_no,
  output logic              dram_lcas_no,
  output logic              dram_ucas_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic [15:0]       dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [15:0]       dram_dq_i
);
  phase_e             phase;
  logic               col_last, accept;
  logic               cur_we;
  logic [1:0]         cur_be;
  logic [ADDR_W-1:0]  cur_addr;
  logic [15:0]        cur_wdata;

  assign req_ready_o = (phase == PH_IDLE) && !refresh_grant_i;
  assign accept      = req_valid_i && req_ready_o;

  edo_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept),
    .phase_o(phase), .col_last_o(col_last)
  );

  edo_req_latch #(.ADDR_W(ADDR_W), .DATA_W(16), .BE_W(2)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .we_i(req_we_i), .be_i(req_be_i), .addr_i(req_addr_i), .wdata_i(req_wdata_i),
    .we_o(cur_we), .be_o(cur_be), .addr_o(cur_addr), .wdata_o(cur_wdata)
  );

  edo_pin_drv #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(16)) u_pins (
    .phase_i(phase), .we_i(cur_we), .be_i(cur_be), .addr_i(cur_addr),
    .wdata_i(cur_wdata), .a_o(dram_a_o), .ras_no(dram_ras_no),
    .lcas_no(dram_lcas_no), .ucas_no(dram_ucas_no), .we_no(dram_we_no),
    .oe_no(dram_oe_no), .dq_o(dram_dq_o), .dq_oe_o(dram_dq_oe_o)
  );

  // sample while OE is still low, before the strobes release
  edo_rd_capture #(.DATA_W(16)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(col_last && !cur_we),
    .dq_i(dram_dq_i), .valid_o(rsp_valid_o), .data_o(rsp_rdata_o)
  );
endmodule

// File: rtl/edo_access_ctrl_chk.sv
module edo_access_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic refresh_grant_i,
  input logic dram_ras_no,
  input logic dram_lcas_no,
  input logic dram_ucas_no,
  input logic dram_we_no,
  input logic dram_oe_no,
  input logic dram_dq_oe_o
);
  logic cas_any;
  assign cas_any = !dram_lcas_no || !dram_ucas_no;

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_any |-> !dram_ras_no); // R4
  AST_WE_BEFORE_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_any && !$past(cas_any) && !dram_we_no) |-> !$past(dram_we_no)); // R6
  AST_OE_OFF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> dram_oe_no); // R7
  AST_DQ_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> !dram_we_no); // R8
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R9
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (dram_ras_no && !cas_any && !dram_dq_oe_o)); // R10
  AST_GRANT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_grant_i |-> (!req_ready_o && dram_ras_no)); // R11
endmodule

bind edo_access_ctrl edo_access_ctrl_chk u_chk (.*);

// File: tb/tb_edo_access_ctrl.sv
module tb_edo_access_ctrl;
  localparam int T_RCD = 2;
  localparam int T_CAS = 3;
  localparam int T_RP  = 2;
  localparam int NVEC  = 7;

  // {we, be[1:0], addr[19:0], wdata[15:0], memory read value[15:0]}
  localparam logic [54:0] VEC [NVEC] = '{
    {1'b1, 2'b11, 20'hABCDE, 16'h1234, 16'h0000},
    {1'b1, 2'b01, 20'h00155, 16'hA5A5, 16'h0000},
    {1'b1, 2'b10, 20'hFFC00, 16'h5A5A, 16'h0000},
    {1'b0, 2'b11, 20'h3FF01, 16'h0000, 16'hC0DE},
    {1'b0, 2'b01, 20'h80201, 16'h0000, 16'h7E81},
    {1'b1, 2'b00, 20'h12345, 16'hFFFF, 16'h0000},
    {1'b0, 2'b10, 20'hFFFFF, 16'h0000, 16'h0F0F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0, grant = 1'b0;
  logic [1:0]  be = '0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0, rval = '0;
  logic        ready, rsp_valid, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [9:0]  a;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  // memory drives data only while its output is enabled
  assign dq_i = oe_n ? 16'h0BAD : rval;

  edo_access_ctrl #(.ROW_W(10), .COL_W(10), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_we_i(we), .req_be_i(be), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata), .refresh_grant_i(grant),
    .dram_a_o(a), .dram_ras_no(ras_n), .dram_lcas_no(lcas_n), .dram_ucas_no(ucas_n),
    .dram_we_no(we_n), .dram_oe_no(oe_n), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe),
    .dram_dq_i(dq_i)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_vec(input logic [54:0] v);
    logic       v_we  = v[54];
    logic [1:0] v_be  = v[53:52];
    logic [9:0] row   = v[51:42];
    logic [9:0] col   = v[41:32];
    logic [1:0] lanes = v_we ? v_be : 2'b11;
    @(negedge clk);
    chk("R2", "ready before request", 32'(ready), 1);
    valid = 1'b1; we = v_we; be = v_be; addr = v[51:32]; wdata = v[31:16]; rval = v[15:0];
    @(negedge clk);
    valid = 1'b0; we = 1'b0; be = '0; addr = '0; wdata = '0;
    for (int i = 0; i < T_RCD; i++) begin
      chk("R3", "ras_n in row", 32'(ras_n), 0);
      chk("R3", "row address", 32'(a), 32'(row));
      chk("R3", "cas in row", 32'({lcas_n, ucas_n}), 32'h3);
      chk("R6", "we_n in row", 32'(we_n), 32'(!v_we));
      chk("R7", "oe_n in row", 32'(oe_n), 1);
      chk("R8", "dq_oe in row", 32'(dq_oe), 32'(v_we));
      chk("R2", "ready busy", 32'(ready), 0);
      @(negedge clk);
    end
    for (int i = 0; i < T_CAS; i++) begin
      chk("R4", "ras_n in col", 32'(ras_n), 0);
      chk("R4", "col address", 32'(a), 32'(col));
      chk("R5", "lcas_n", 32'(lcas_n), 32'(!lanes[0]));
      chk("R5", "ucas_n", 32'(ucas_n), 32'(!lanes[1]));
      chk("R6", "we_n in col", 32'(we_n), 32'(!v_we));
      chk("R7", "oe_n in col", 32'(oe_n), 32'(v_we));
      chk("R8", "dq_oe in col", 32'(dq_oe), 32'(v_we));
      if (v_we) chk("R8", "dq_o", 32'(dq_o), 32'(v[31:16]));
      chk("R9", "no early rsp", 32'(rsp_valid), 0);
      @(negedge clk);
    end
    for (int i = 0; i < T_RP; i++) begin
      if (i == 0) begin
        chk("R9", "rsp_valid pulse", 32'(rsp_valid), 32'(!v_we));
        if (!v_we) chk("R9", "read data", 32'(rdata), 32'(v[15:0]));
      end else chk("R9", "rsp single cycle", 32'(rsp_valid), 0);
      chk("R10", "strobes in precharge", 32'({ras_n, lcas_n, ucas_n, we_n, oe_n}), 32'h1F);
      chk("R10", "dq_oe in precharge", 32'(dq_oe), 0);
      chk("R2", "ready in precharge", 32'(ready), 0);
      @(negedge clk);
    end
    chk("R10", "ready after precharge", 32'(ready), 1);
    chk("R9", "rsp low after", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", 32'(ready), 1);
    chk("R1", "strobes in reset", 32'({ras_n, lcas_n, ucas_n, we_n, oe_n}), 32'h1F);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", 32'(ready), 1);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R1", "dq_oe after reset", 32'(dq_oe), 0);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R11: grant blocks acceptance even with a request waiting
    @(negedge clk);
    grant = 1'b1; valid = 1'b1; we = 1'b1; be = 2'b11; addr = 20'h55555;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11", "ready under grant", 32'(ready), 0);
      chk("R11", "ras_n under grant", 32'(ras_n), 1);
    end
    valid = 1'b0;
    grant = 1'b0;
    @(negedge clk);
    chk("R11", "ready after grant", 32'(ready), 1);
    chk("R11", "no access started", 32'(ras_n), 1);

    // back-to-back reads after the grant
    run_vec({1'b0, 2'b11, 20'h00000, 16'h0000, 16'hFFFF});
    run_vec({1'b0, 2'b11, 20'hFFFFF, 16'h0000, 16'h0001});
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule